// File: doc/BRIEF.md
# Complex-Sample Stream Capture Sink

This block terminates a 32-bit valid/ready sample stream (AXI4-Stream style) and stores every accepted beat in an internal word memory, one word per beat, at rising addresses that start from word 0. Software programs how many blocks to expect; once the number of beats equals that block count times a fixed block length, the block stops accepting data and shows a sticky completion flag. A test harness can then read the captured words back over a 32-bit memory-mapped bus and compare them with expected results.

The bus address space has two parts. Byte addresses with the top address bit clear select the capture memory: word k sits at byte address 4k and aliases modulo the memory depth. Byte addresses with the top address bit set (offset 0x8_0000 at the default 20-bit width) select a small register window: identity at +0x00, soft reset at +0x04, block count at +0x0C and completion status at +0x20.

A three-state machine runs the capture. HOLD is entered whenever soft reset is set and is left for CAPT when soft reset is cleared. CAPT accepts beats and moves to FULL on the beat that brings the total to the target, or moves back to HOLD on soft reset. FULL refuses beats and moves back to HOLD only on soft reset. After hardware reset the machine is in CAPT with a block count of zero, which means capture without end.

Top module: `cplx_capture_sink`

## Requirements
- R1: A read of window offset 0x00 (byte address 0x80000) returns the identity parameter ID_VAL.
- R2: Window offset 0x04 bit 0 is a soft reset that reads back as written. While it is 1, s_tready is 0 and the status reads 0. After it is cleared, the next accepted beat is stored at word 0.
- R3: Window offset 0x0C holds a 12-bit block count in bits 11:0. Bits 31:12 read as zero, whatever value was written.
- R4: Each accepted beat (s_tvalid and s_tready high at a clock edge) is written to the word after the one before, starting at word 0. Word k is read at byte address 4k.
- R5: Status bit 0 at window offset 0x20 reads 0 until exactly count x BLK_LEN beats have been accepted and reads 1 from then on.
- R6: Once complete, s_tready stays 0, no further beat changes the memory, and the status stays 1 until soft reset.
- R7: With a block count of zero, completion never occurs and the write position wraps modulo DEPTH.
- R8: A read strobe gives bus_rvalid=1 with the data in the following cycle, and bus_rvalid=0 in the cycle after a cycle without a strobe. Unmapped window offsets read as 0.
- R9: Bus writes to the identity register, to the status register or to the memory region have no effect.
- R10: After hardware reset the soft reset bit is 0, the block count is 0, the status is 0 and s_tready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| s_tdata | input | 32 | Stream sample: one complex value packed as I/Q halves |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Sink can accept a beat |
| bus_addr | input | ADDR_W | Byte address of the bus access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The bench goes through the block counts 1 to 7 with BLK_LEN=8 and DEPTH=64. It checks the status on the cycle before the last beat and on the cycle after it, so a design whose comparison is off by one shows up either as early completion or as one extra stored word. After completion, the bench offers more beats and then reads every memory word against a model. A sink that kept tready high, or that dropped a beat and wrote it later, would corrupt the word just past the target. A run with a block count of zero sends more beats than the depth: a design that ends capture on count zero, or that does not wrap, fails the done check or the low words. Each run begins with a soft reset, so a pointer that is not cleared puts the first word of a run in the wrong place.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_CAPT = 2'd1,
        ST_FULL = 2'd2
    } cap_state_e;

    localparam logic [7:0] OFS_IDENT = 8'h00;
    localparam logic [7:0] OFS_SRST  = 8'h04;
    localparam logic [7:0] OFS_COUNT = 8'h0C;
    localparam logic [7:0] OFS_STAT  = 8'h20;
endpackage

// File: rtl/ccs_regs.sv
module ccs_regs
    import ccs_pkg::*;
#(
    parameter logic [31:0] ID_VAL  = 32'h5CA9_0001,
    parameter int          NITER_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         ofs,
    input  logic [31:0]        wdata,
    input  logic               done_in,
    output logic               soft_rst,
    output logic [NITER_W-1:0] niter,
    output logic [31:0]        rd_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_rst <= 1'b0;
            niter    <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_SRST:  soft_rst <= wdata[0];
                OFS_COUNT: niter    <= wdata[NITER_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (ofs)
            OFS_IDENT: rd_word = ID_VAL;
            OFS_SRST:  rd_word = {31'd0, soft_rst};
            OFS_COUNT: rd_word = {{(32-NITER_W){1'b0}}, niter};
            OFS_STAT:  rd_word = {31'd0, done_in};
            default:   rd_word = '0;
        endcase
    end

    // R3: the stored count follows the write data only through its low field
    assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_COUNT) |=> (niter == $past(wdata[NITER_W-1:0])));
endmodule

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
    import ccs_pkg::*;
#(
    parameter int BLK_LEN = 8,
    parameter int DEPTH   = 64,
    parameter int NITER_W = 12,
    localparam int CNT_W  = NITER_W + $clog2(BLK_LEN) + 1,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [NITER_W-1:0] niter,
    input  logic               s_tvalid,
    output logic               s_tready,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic               done
);
    cap_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt, target;

    assign target  = CNT_W'(niter) * CNT_W'(BLK_LEN);
    assign cnt_nxt = cnt + CNT_W'(wr_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CAPT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: if (!soft_rst) nxt = ST_CAPT;
            ST_CAPT: begin
                if (soft_rst)                                 nxt = ST_HOLD;
                else if (target != '0 && cnt_nxt >= target)   nxt = ST_FULL;
            end
            ST_FULL: if (soft_rst) nxt = ST_HOLD;
            default: nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        s_tready = (state == ST_CAPT);
        done     = (state == ST_FULL);
        wr_en    = s_tready && s_tvalid;
        wr_idx   = cnt[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (soft_rst) cnt <= '0;
        else if (wr_en)    cnt <= cnt_nxt;
    end

    // R4: every accepted beat moves the write position by one
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> (cnt == $past(cnt) + 1'b1));
    // R2: soft reset empties the counter and blocks the stream
    assert_srst_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cnt == '0 && !done && !s_tready));
    // R5: completion only once the programmed total is reached
    assert_done_at_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (target != '0 && cnt >= target));
    // R6: completion is sticky and stores nothing more
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !soft_rst) |=> (done && !wr_en && $stable(cnt)));
    // R7: a zero block count never completes
    assert_forever_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (niter == '0 && !done) |=> !done);
endmodule

// File: rtl/ccs_mem.sv
module ccs_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end
endmodule

// File: rtl/cplx_capture_sink.sv
module cplx_capture_sink
    import ccs_pkg::*;
#(
    parameter logic [31:0] ID_VAL  = 32'h5CA9_0001,
    parameter int          BLK_LEN = 8,
    parameter int          DEPTH   = 64,
    parameter int          ADDR_W  = 20,
    parameter int          NITER_W = 12,
    localparam int         MEM_AW  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);
    logic               win_hit, reg_wr, soft_rst, done, cap_we;
    logic [NITER_W-1:0] niter;
    logic [31:0]        reg_word, reg_q, mem_q;
    logic [MEM_AW-1:0]  cap_idx;
    logic               sel_reg_q;

    assign win_hit = bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:8] == '0);
    assign reg_wr  = bus_wr && win_hit;

    ccs_regs #(.ID_VAL(ID_VAL), .NITER_W(NITER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .ofs(bus_addr[7:0]),
        .wdata(bus_wdata), .done_in(done), .soft_rst(soft_rst),
        .niter(niter), .rd_word(reg_word)
    );

    ccs_ctrl #(.BLK_LEN(BLK_LEN), .DEPTH(DEPTH), .NITER_W(NITER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .niter(niter),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .wr_en(cap_we),
        .wr_idx(cap_idx), .done(done)
    );

    ccs_mem #(.DEPTH(DEPTH), .DW(32)) u_mem (
        .clk(clk), .we(cap_we), .waddr(cap_idx), .wdata(s_tdata),
        .raddr(bus_addr[MEM_AW+1:2]), .rdata(mem_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            sel_reg_q  <= 1'b0;
            reg_q      <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                sel_reg_q <= bus_addr[ADDR_W-1];
                reg_q     <= win_hit ? reg_word : 32'd0;
            end
        end
    end

    assign bus_rdata = sel_reg_q ? reg_q : mem_q;

    // R8: read data valid exactly one cycle after each strobe
    assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    assert_rvalid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R6: status held high means the stream stays stalled
    assert_stall_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !soft_rst) |=> !s_tready);
endmodule

// File: tb/sim_cplx_capture_sink.sv
module sim_cplx_capture_sink;
    localparam int          BLK  = 8;
    localparam int          DEP  = 64;
    localparam logic [31:0] IDV  = 32'h5CA9_0001;
    localparam logic [19:0] WIN  = 20'h80000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [19:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] exp_mem [DEP];
    bit          exp_ok  [DEP];
    int          mcnt = 0;

    always #2.5 clk = ~clk;

    cplx_capture_sink #(.ID_VAL(IDV), .BLK_LEN(BLK), .DEPTH(DEP)) u0 (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R8 rvalid", {31'd0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    // drive n beats with a gap pattern; the model stores what the sink accepts
    task automatic stream(input int n, input int tag);
        int sent = 0;
        int cyc = 0;
        while (sent < n) begin
            @(negedge clk);
            if (((cyc * 3 + tag) % 4) == 0) begin
                s_tvalid = 1'b0;
            end else begin
                s_tvalid = 1'b1;
                s_tdata  = {tag[7:0], 8'hC3, sent[15:0]} ^ 32'h0F0F_0000;
                if (s_tready) begin
                    exp_mem[mcnt % DEP] = s_tdata;
                    exp_ok[mcnt % DEP]  = 1'b1;
                    mcnt++;
                end
                sent++;
            end
            cyc++;
        end
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic check_mem(input string req);
        logic [31:0] d;
        for (int k = 0; k < DEP; k++) begin
            if (exp_ok[k]) begin
                bread(20'(k * 4), d);
                check(req, d, exp_mem[k]);
            end
        end
    endtask

    initial begin
        logic [31:0] d;
        for (int k = 0; k < DEP; k++) exp_ok[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 tready", {31'd0, s_tready}, 32'd1);
        check("R10 rvalid idle", {31'd0, bus_rvalid}, 32'd0);
        bread(WIN + 20'h00, d); check("R1 ident", d, IDV);
        bread(WIN + 20'h04, d); check("R10 srst", d, 32'd0);
        bread(WIN + 20'h0C, d); check("R10 count", d, 32'd0);
        bread(WIN + 20'h20, d); check("R10 status", d, 32'd0);
        @(negedge clk);
        check("R8 rvalid low", {31'd0, bus_rvalid}, 32'd0);

        bwrite(WIN + 20'h00, 32'hDEAD_BEEF);
        bread(WIN + 20'h00, d); check("R9 ident write", d, IDV);
        bwrite(WIN + 20'h20, 32'h1);
        bread(WIN + 20'h20, d); check("R9 status write", d, 32'd0);
        bwrite(WIN + 20'h0C, 32'hFFFF_FFFF);
        bread(WIN + 20'h0C, d); check("R3 count width", d, 32'h0000_0FFF);
        bwrite(WIN + 20'h0C, 32'hABC0_0005);
        bread(WIN + 20'h0C, d); check("R3 count load", d, 32'h0000_0005);
        bread(WIN + 20'h10, d); check("R8 unmapped", d, 32'd0);
        bread(WIN + 20'h24, d); check("R8 unmapped", d, 32'd0);

        // R7: zero count captures forever and wraps
        bwrite(WIN + 20'h04, 32'h1);
        @(negedge clk);
        check("R2 tready held", {31'd0, s_tready}, 32'd0);
        bread(WIN + 20'h04, d); check("R2 srst readback", d, 32'd1);
        bwrite(WIN + 20'h0C, 32'h0);
        bwrite(WIN + 20'h04, 32'h0);
        mcnt = 0;
        stream(DEP + 6, 0);
        bread(WIN + 20'h20, d); check("R7 never done", d, 32'd0);
        check("R7 still ready", {31'd0, s_tready}, 32'd1);
        check_mem("R7 wrap");
        bwrite(20'h0, 32'h1234_5678);
        check_mem("R9 memory write ignored");

        for (int n = 1; n < 8; n++) begin
            bwrite(WIN + 20'h04, 32'h1);
            bread(WIN + 20'h20, d); check("R2 status cleared", d, 32'd0);
            check("R2 tready low", {31'd0, s_tready}, 32'd0);
            bwrite(WIN + 20'h0C, 32'(n));
            bwrite(WIN + 20'h04, 32'h0);
            mcnt = 0;
            stream(n * BLK - 1, n);
            bread(WIN + 20'h20, d); check("R5 not yet done", d, 32'd0);
            check("R5 ready before last", {31'd0, s_tready}, 32'd1);
            stream(1, n + 16);
            check("R6 tready after done", {31'd0, s_tready}, 32'd0);
            bread(WIN + 20'h20, d); check("R5 done", d, 32'd1);
            check("R4 beat total", 32'(mcnt), 32'(n * BLK));
            stream(3, n + 32);
            check("R6 still stalled", {31'd0, s_tready}, 32'd0);
            bread(WIN + 20'h20, d); check("R6 sticky", d, 32'd1);
            check_mem("R4/R6 memory");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule